// File: doc/BRIEF.md
# Dual-Half Single-Cycle SIMD Integer Unit

This block is a one-cycle execution stage. Its 64-bit datapath is split into an upper and a lower 32-bit half. An operation enters with an opcode, two 64-bit operands, a vector/scalar flag and a destination tag. One clock later it leaves with a 64-bit result, a 4-bit condition field and the same tag.

The unit covers:
- bitwise logic;
- 32-bit add and subtract within each half;
- merges and splats that move halves around;
- sign-bit operations on single-precision floats (absolute value, negative absolute value and negate);
- equal, greater-than and less-than tests on single-precision floats.

The float operations are done as plain integer bit work. A vector operation drives both halves at once. A scalar operation computes only the lower half.

Both sides of the block are valid/ready streams, and the result sits in a single output register.
- An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty, or is being drained in that same cycle (`out_ready` high).
- While `out_valid` is high and `out_ready` is low, the output holds steady and no new operation is accepted.
- With `out_ready` tied high, one operation can issue every cycle, and each finishes exactly one cycle after it issues.

Top module: `simd_dual_unit`

## Requirements
- R1: An operation accepted on a clock edge appears at the output after that edge, with `out_valid` high and `out_tag` equal to its issue tag. With `out_ready` high, operations issued on consecutive cycles come out on consecutive cycles.
- R2: While `out_valid` is high and `out_ready` is low, `out_result`, `out_cond` and `out_tag` hold steady and `in_ready` is low.
- R3: After reset, `out_valid` is low and `in_ready` is high.
- R4: The logic codes work bitwise on the active halves: 0 AND, 1 OR, 2 XOR, 3 NAND, 4 NOR, 5 A AND NOT B.
- R5: Code 6 (A+B) and code 7 (A−B) work modulo 2^32 in each active half, and no carry or borrow crosses between the halves.
- R6: When `in_vec` is 0, the logic, add/subtract and float-sign codes compute only bits 31:0. Bits 63:32 of the result equal bits 63:32 of operand A.
- R7: The merge and splat codes always produce all 64 bits, whatever `in_vec` is:
  - 8 gives {A.hi, B.hi};
  - 9 gives {A.lo, B.lo};
  - 10 gives {A.hi, B.lo};
  - 11 gives {A.lo, B.hi};
  - 12 gives {A.lo, A.lo}.
- R8: Within each active half, and changing no other bit, code 13 clears the sign bit (bit 31, and bit 63 in vector mode), code 14 sets it and code 15 inverts it.
- R9: Codes 16 (equal), 17 (A greater than B) and 18 (A less than B) compare the sign-magnitude values of each active half. +0 and −0 count as equal. The result word is zero.
- R10: The `out_cond` field is laid out as follows:
  - bit 0 is the lower-half test;
  - bit 1 is the upper-half test, which is always 0 in scalar mode;
  - bit 2 is the OR of the active half tests;
  - bit 3 is the AND of the active half tests.
  All four bits are 0 for every code that is not a test.
- R11: Codes 19 to 31 produce a zero result and a zero `out_cond`. They still finish with their tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation |
| in_op | input | 5 | Operation code |
| in_vec | input | 1 | 1 = vector (both halves), 0 = scalar (lower half) |
| in_a | input | 64 | Operand A |
| in_b | input | 64 | Operand B |
| in_tag | input | TAG_W (6) | Destination tag |
| out_valid | output | 1 | Result present (finish strobe) |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Result word |
| out_cond | output | 4 | Condition field {all, any, upper, lower} |
| out_tag | output | TAG_W (6) | Tag of the finishing operation |

## Verification
The bench adds operands that overflow exactly at the half boundary. A unit that let the carry cross between halves would return a nonzero upper word where zero is expected.

It feeds scalar operations with distinct upper words in A. A unit that computed or zeroed the upper half would lose A's upper bits.

It compares −0 against +0, and negative against negative. A plain unsigned or two's-complement compare would mark the zeros unequal and would order the negatives backwards. Vector tests check the four condition bits separately, which exposes swapped OR/AND summaries.

A stall with a second operation waiting shows whether the held result is overwritten. It also shows whether the queued operation is lost or duplicated when the stall ends.

// File: rtl/simd_dual_pkg.sv
package simd_dual_pkg;

  localparam int OP_W   = 5;
  localparam int COND_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_AND   = 5'd0,
    OP_OR    = 5'd1,
    OP_XOR   = 5'd2,
    OP_NAND  = 5'd3,
    OP_NOR   = 5'd4,
    OP_ANDC  = 5'd5,
    OP_ADD   = 5'd6,
    OP_SUB   = 5'd7,
    OP_MHH   = 5'd8,
    OP_MLL   = 5'd9,
    OP_MHL   = 5'd10,
    OP_MLH   = 5'd11,
    OP_SPLAT = 5'd12,
    OP_FABS  = 5'd13,
    OP_FNABS = 5'd14,
    OP_FNEG  = 5'd15,
    OP_FTEQ  = 5'd16,
    OP_FTGT  = 5'd17,
    OP_FTLT  = 5'd18
  } op_e;

  // Codes computed per half by the lane slices
  function automatic logic op_is_lane(input logic [OP_W-1:0] op);
    return (op <= 5'd7) || (op >= 5'd13 && op <= 5'd15);
  endfunction

  // Codes that move whole halves
  function automatic logic op_is_perm(input logic [OP_W-1:0] op);
    return (op >= 5'd8) && (op <= 5'd12);
  endfunction

  // Float test codes
  function automatic logic op_is_cmp(input logic [OP_W-1:0] op);
    return (op >= 5'd16) && (op <= 5'd18);
  endfunction

  typedef struct packed {
    logic all_f;
    logic any_f;
    logic hi_f;
    logic lo_f;
  } cond_t;

endpackage

// File: rtl/simd_half_lane.sv
module simd_half_lane
  import simd_dual_pkg::*;
#(
  parameter int HW = 32
) (
  input  logic [OP_W-1:0] op,
  input  logic [HW-1:0]   a,
  input  logic [HW-1:0]   b,
  output logic [HW-1:0]   res,
  output logic            flag
);

  localparam int MAG_W = HW - 1;

  logic [MAG_W-1:0]  mag_a, mag_b;
  logic signed [HW-1:0] key_a, key_b;
  logic eq_f, gt_f, lt_f;

  assign mag_a = a[MAG_W-1:0];
  assign mag_b = b[MAG_W-1:0];

  // Map sign-magnitude onto an ordered signed key; both zeros map to 0
  assign key_a = a[HW-1] ? -$signed({1'b0, mag_a}) : $signed({1'b0, mag_a});
  assign key_b = b[HW-1] ? -$signed({1'b0, mag_b}) : $signed({1'b0, mag_b});

  assign eq_f = (key_a == key_b);
  assign gt_f = (key_a >  key_b);
  assign lt_f = (key_a <  key_b);

  always_comb begin
    res = '0;
    unique case (op_e'(op))
      OP_AND:   res = a & b;
      OP_OR:    res = a | b;
      OP_XOR:   res = a ^ b;
      OP_NAND:  res = ~(a & b);
      OP_NOR:   res = ~(a | b);
      OP_ANDC:  res = a & ~b;
      OP_ADD:   res = a + b;
      OP_SUB:   res = a - b;
      OP_FABS:  res = {1'b0, mag_a};
      OP_FNABS: res = {1'b1, mag_a};
      OP_FNEG:  res = {~a[HW-1], mag_a};
      default:  res = '0;
    endcase
  end

  always_comb begin
    flag = 1'b0;
    unique case (op_e'(op))
      OP_FTEQ: flag = eq_f;
      OP_FTGT: flag = gt_f;
      OP_FTLT: flag = lt_f;
      default: flag = 1'b0;
    endcase
  end

endmodule

// File: rtl/simd_half_perm.sv
module simd_half_perm
  import simd_dual_pkg::*;
#(
  parameter int HW = 32
) (
  input  logic [OP_W-1:0] op,
  input  logic [2*HW-1:0] a,
  input  logic [2*HW-1:0] b,
  output logic [2*HW-1:0] res
);

  logic [HW-1:0] a_hi, a_lo, b_hi, b_lo;

  assign a_hi = a[2*HW-1:HW];
  assign a_lo = a[HW-1:0];
  assign b_hi = b[2*HW-1:HW];
  assign b_lo = b[HW-1:0];

  always_comb begin
    res = '0;
    unique case (op_e'(op))
      OP_MHH:   res = {a_hi, b_hi};
      OP_MLL:   res = {a_lo, b_lo};
      OP_MHL:   res = {a_hi, b_lo};
      OP_MLH:   res = {a_lo, b_hi};
      OP_SPLAT: res = {a_lo, a_lo};
      default:  res = '0;
    endcase
  end

endmodule

// File: rtl/simd_dual_unit.sv
module simd_dual_unit
  import simd_dual_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int TAG_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic              in_vec,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic [COND_W-1:0] out_cond,
  output logic [TAG_W-1:0]  out_tag
);

  localparam int HW      = DATA_W / 2;
  localparam int N_HALF  = 2;

  logic [HW-1:0] lane_res  [N_HALF];
  logic          lane_flag [N_HALF];
  logic [DATA_W-1:0] perm_res;
  logic [DATA_W-1:0] nxt_result;
  cond_t             nxt_cond;
  logic is_lane, is_perm, is_cmp, fire;

  for (genvar g = 0; g < N_HALF; g++) begin : g_half
    simd_half_lane #(.HW(HW)) lane_i (
      .op   (in_op),
      .a    (in_a[g*HW +: HW]),
      .b    (in_b[g*HW +: HW]),
      .res  (lane_res[g]),
      .flag (lane_flag[g])
    );
  end

  simd_half_perm #(.HW(HW)) perm_i (
    .op  (in_op),
    .a   (in_a),
    .b   (in_b),
    .res (perm_res)
  );

  assign is_lane = op_is_lane(in_op);
  assign is_perm = op_is_perm(in_op);
  assign is_cmp  = op_is_cmp(in_op);

  always_comb begin
    nxt_result = '0;
    if (is_perm)
      nxt_result = perm_res;
    else if (is_lane)
      nxt_result = {(in_vec ? lane_res[1] : in_a[DATA_W-1:HW]), lane_res[0]};
  end

  always_comb begin
    nxt_cond.lo_f  = is_cmp & lane_flag[0];
    nxt_cond.hi_f  = is_cmp & in_vec & lane_flag[1];
    nxt_cond.any_f = in_vec ? (nxt_cond.lo_f | nxt_cond.hi_f) : nxt_cond.lo_f;
    nxt_cond.all_f = in_vec ? (nxt_cond.lo_f & nxt_cond.hi_f) : nxt_cond.lo_f;
  end

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_cond   <= '0;
      out_tag    <= '0;
    end else if (fire) begin
      out_valid  <= 1'b1;
      out_result <= nxt_result;
      out_cond   <= nxt_cond;
      out_tag    <= in_tag;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

endmodule

// File: rtl/simd_dual_unit_chk.sv
module simd_dual_unit_chk
  import simd_dual_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int TAG_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [OP_W-1:0]   in_op,
  input logic              in_vec,
  input logic [DATA_W-1:0] in_a,
  input logic [DATA_W-1:0] in_b,
  input logic [TAG_W-1:0]  in_tag,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic [COND_W-1:0] out_cond,
  input logic [TAG_W-1:0]  out_tag
);

  localparam int HW = DATA_W / 2;

  logic acc;
  assign acc = in_valid && in_ready;

  // R1
  a_r1_finish_tag: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (out_valid && out_tag == $past(in_tag)));

  // R2
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)
                                   && $stable(out_cond) && $stable(out_tag)));

  a_r2_stall_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R6
  a_r6_scalar_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_vec && op_is_lane(in_op)) |=>
      (out_result[DATA_W-1:HW] == $past(in_a[DATA_W-1:HW])));

  // R9
  a_r9_cmp_zero_word: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op_is_cmp(in_op)) |=> (out_result == '0));

  // R10
  a_r10_any_summary: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_cond[2] == (out_cond[0] | out_cond[1])));

  a_r10_all_implies_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cond[3]) |-> out_cond[0]);

  a_r10_non_test_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !op_is_cmp(in_op)) |=> (out_cond == '0));

  a_r10_scalar_no_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_vec) |=> !out_cond[1]);

endmodule

bind simd_dual_unit simd_dual_unit_chk #(.DATA_W(DATA_W), .TAG_W(TAG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_vec(in_vec), .in_a(in_a), .in_b(in_b), .in_tag(in_tag),
  .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
  .out_cond(out_cond), .out_tag(out_tag)
);

// File: tb/simd_dual_unit_tb_top.sv
module simd_dual_unit_tb_top;

  localparam int DW = 64;
  localparam int TW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [4:0]    in_op = '0;
  logic          in_vec = 1'b0;
  logic [DW-1:0] in_a = '0;
  logic [DW-1:0] in_b = '0;
  logic [TW-1:0] in_tag = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [DW-1:0] out_result;
  logic [3:0]    out_cond;
  logic [TW-1:0] out_tag;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  simd_dual_unit #(.DATA_W(DW), .TAG_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_vec(in_vec), .in_a(in_a), .in_b(in_b), .in_tag(in_tag),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_cond(out_cond), .out_tag(out_tag)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] op, input logic vec,
                       input logic [63:0] a, input logic [63:0] b, input logic [5:0] tag);
    in_valid = 1'b1; in_op = op; in_vec = vec; in_a = a; in_b = b; in_tag = tag;
  endtask

  // Issue one op with out_ready high, check result/cond/tag
  task automatic run_op(input string req, input logic [4:0] op, input logic vec,
                        input logic [63:0] a, input logic [63:0] b,
                        input logic [63:0] exp_res, input logic [3:0] exp_cond);
    @(negedge clk);
    drive(op, vec, a, b, 6'(op + 7));
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, 64'(out_valid), 64'd1);
    chk({req, " result"}, out_result, exp_res);
    chk({req, " cond"}, 64'(out_cond), 64'(exp_cond));
    chk({req, " tag"}, 64'(out_tag), 64'(6'(op + 7)));
  endtask

  task automatic t_reset();
    chk("R3 out_valid after reset", 64'(out_valid), 64'd0);
    chk("R3 in_ready after reset", 64'(in_ready), 64'd1);
  endtask

  task automatic t_logic();
    run_op("R4 vector AND", 5'd0, 1'b1, 64'hF0F0F0F0_12345678, 64'h0FF00FF0_FFFF0000,
           64'h00F000F0_12340000, 4'b0000);
    run_op("R4 vector ANDC", 5'd5, 1'b1, 64'hFFFFFFFF_FFFFFFFF, 64'h0000FFFF_F0F0F0F0,
           64'hFFFF0000_0F0F0F0F, 4'b0000);
    run_op("R4 vector OR", 5'd1, 1'b1, 64'h0000000F_00F00000, 64'h000000F0_0F000000,
           64'h000000FF_0FF00000, 4'b0000);
    run_op("R4 vector NAND", 5'd3, 1'b1, 64'hFFFFFFFF_0000FFFF, 64'hFFFF0000_FFFFFFFF,
           64'h0000FFFF_FFFF0000, 4'b0000);
    run_op("R6 scalar XOR", 5'd2, 1'b0, 64'hAAAAAAAA_0000FFFF, 64'h55555555_FFFFFFFF,
           64'hAAAAAAAA_FFFF0000, 4'b0000);
    run_op("R6 scalar NOR", 5'd4, 1'b0, 64'h12345678_00000000, 64'h00000000_0000000F,
           64'h12345678_FFFFFFF0, 4'b0000);
  endtask

  task automatic t_arith();
    run_op("R5 vector ADD no cross carry", 5'd6, 1'b1, 64'hFFFFFFFF_00000001,
           64'h00000001_FFFFFFFF, 64'h00000000_00000000, 4'b0000);
    run_op("R5 vector SUB no cross borrow", 5'd7, 1'b1, 64'h00000000_00000005,
           64'h00000001_00000007, 64'hFFFFFFFF_FFFFFFFE, 4'b0000);
    run_op("R6 scalar ADD", 5'd6, 1'b0, 64'h11111111_7FFFFFFF, 64'h22222222_00000001,
           64'h11111111_80000000, 4'b0000);
  endtask

  task automatic t_perm();
    run_op("R7 MHH scalar flag", 5'd8, 1'b0, 64'hAAAAAAAA_BBBBBBBB, 64'hCCCCCCCC_DDDDDDDD,
           64'hAAAAAAAA_CCCCCCCC, 4'b0000);
    run_op("R7 MLL", 5'd9, 1'b1, 64'hAAAAAAAA_BBBBBBBB, 64'hCCCCCCCC_DDDDDDDD,
           64'hBBBBBBBB_DDDDDDDD, 4'b0000);
    run_op("R7 MHL", 5'd10, 1'b0, 64'hAAAAAAAA_BBBBBBBB, 64'hCCCCCCCC_DDDDDDDD,
           64'hAAAAAAAA_DDDDDDDD, 4'b0000);
    run_op("R7 MLH", 5'd11, 1'b1, 64'hAAAAAAAA_BBBBBBBB, 64'hCCCCCCCC_DDDDDDDD,
           64'hBBBBBBBB_CCCCCCCC, 4'b0000);
    run_op("R7 SPLAT scalar flag", 5'd12, 1'b0, 64'hAAAAAAAA_BBBBBBBB, 64'h0,
           64'hBBBBBBBB_BBBBBBBB, 4'b0000);
  endtask

  task automatic t_fsign();
    run_op("R8 vector FNEG", 5'd15, 1'b1, 64'h3F800000_BF800000, 64'h0,
           64'hBF800000_3F800000, 4'b0000);
    run_op("R8 scalar FABS", 5'd13, 1'b0, 64'h80000001_C0000000, 64'h0,
           64'h80000001_40000000, 4'b0000);
    run_op("R8 vector FNABS", 5'd14, 1'b1, 64'h00000005_12345678, 64'h0,
           64'h80000005_92345678, 4'b0000);
  endtask

  task automatic t_fcmp();
    run_op("R9 vector FTGT neg vs neg", 5'd17, 1'b1, 64'h3F800000_BF800000,
           64'hC0000000_C0000000, 64'h0, 4'b1111);
    run_op("R9 vector FTLT", 5'd18, 1'b1, 64'h3F800000_BF800000,
           64'hC0000000_C0000000, 64'h0, 4'b0000);
    run_op("R10 vector FTEQ zero signs", 5'd16, 1'b1, 64'h80000000_3F800000,
           64'h00000000_3F800001, 64'h0, 4'b0110);
    run_op("R10 scalar FTEQ -0 vs +0", 5'd16, 1'b0, 64'hFFFFFFFF_80000000,
           64'h12345678_00000000, 64'h0, 4'b1101);
    run_op("R9 scalar FTLT -2 vs -1", 5'd18, 1'b0, 64'h0_C0000000,
           64'h0_BF800000, 64'h0, 4'b1101);
  endtask

  task automatic t_unknown();
    run_op("R11 unused code", 5'd25, 1'b1, 64'hDEADBEEF_CAFEF00D, 64'h12345678_9ABCDEF0,
           64'h0, 4'b0000);
  endtask

  task automatic t_stream();
    @(negedge clk);
    out_ready = 1'b1;
    drive(5'd6, 1'b1, 64'h1_00000001, 64'h1_00000001, 6'd1);
    @(negedge clk);
    chk("R1 b2b first tag", 64'(out_tag), 64'd1);
    chk("R1 b2b first result", out_result, 64'h2_00000002);
    drive(5'd2, 1'b1, 64'hF, 64'h3, 6'd2);
    @(negedge clk);
    chk("R1 b2b second valid", 64'(out_valid), 64'd1);
    chk("R1 b2b second tag", 64'(out_tag), 64'd2);
    chk("R1 b2b second result", out_result, 64'hC);
    drive(5'd12, 1'b0, 64'h5, 64'h0, 6'd3);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 b2b third tag", 64'(out_tag), 64'd3);
    chk("R1 b2b third result", out_result, 64'h5_00000005);
    @(negedge clk);
    chk("R1 drains when idle", 64'(out_valid), 64'd0);
    // Stall
    out_ready = 1'b0;
    drive(5'd1, 1'b1, 64'hA0, 64'h0B, 6'd4);
    @(negedge clk);
    drive(5'd1, 1'b1, 64'h100, 64'h001, 6'd5);
    chk("R2 stall in_ready low", 64'(in_ready), 64'd0);
    @(negedge clk);
    @(negedge clk);
    chk("R2 held valid", 64'(out_valid), 64'd1);
    chk("R2 held tag", 64'(out_tag), 64'd4);
    chk("R2 held result", out_result, 64'hAB);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 queued op tag", 64'(out_tag), 64'd5);
    chk("R2 queued op result", out_result, 64'h101);
    @(negedge clk);
    chk("R2 no duplicate", 64'(out_valid), 64'd0);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_logic();
    t_arith();
    t_perm();
    t_fsign();
    t_fcmp();
    t_unknown();
    t_stream();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      summary();
    end
  end

endmodule